// File: doc/BRIEF.md
# Probe Capture Engine with Serial Host Link

This block is an embedded logic analyzer. Four probe inputs are packed into one sample word every clock. A host on a serial line arms the block with a single command byte. While armed, the block watches two Boolean trigger terms. As soon as either term is true, it records a fixed number of consecutive samples into internal memory.

Once the memory is full, the block sends the whole record back to the host with no further request. Each sample goes out as one byte, oldest first, over the same serial link. The block then returns to its idle state and can be armed again.

The serial link is 8 data bits, no parity and one stop bit. The bit period in clocks is the integer quotient of the clock rate and the baud rate.

Top module: `la_capture_core`

## Requirements
- R1: After a synchronous reset the block is idle, and `uart_tx` stays high with no byte sent until the block has been armed and has triggered.
- R2: A received byte of 0x30 in the idle state arms the block. Any other byte received while idle has no effect: a following trigger condition causes no transmission.
- R3: While armed, capture starts when either trigger term is true. Term A is `probe_a & probe_b & ~probe_c`. Term B is `probe_d == TRIG_D_CODE`, where the default code is 3'b101. While armed and neither term is true, nothing is sent.
- R4: The sample word is `{probe_a, probe_b, probe_c, probe_d}`, so `probe_a` is the most significant bit. Each sample is sent zero-extended to 8 bits.
- R5: The first stored sample is the one present on the clock edge at which a trigger term is first seen true. One sample is then stored on every following clock until DEPTH samples are held.
- R6: Readout sends exactly DEPTH bytes in capture order, oldest first. Each byte is framed as one low start bit, 8 data bits LSB first and one high stop bit, and every bit lasts CLK_HZ/BAUD clocks.
- R7: After the stop bit of the last byte the block is idle again, and a new 0x30 arms it for a fresh capture.
- R8: A 0x30 byte received while capturing or reading out is ignored: the readout stays exactly DEPTH bytes long and no second readout follows.
- R9: A synchronous reset asserted during capture abandons that capture: `uart_tx` goes high and no byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| uart_rx | input | 1 | Serial input from the host, idle high |
| uart_tx | output | 1 | Serial output to the host, idle high |
| probe_a | input | 1 | Probe, sample bit SW-1 |
| probe_b | input | 1 | Probe, sample bit SW-2 |
| probe_c | input | 1 | Probe, sample bit SW-3 |
| probe_d | input | D_W | Multi-bit probe, lowest sample bits |

## Verification
Two functions can meet in the same stretch of cycles. The command decoder may complete a 0x30 byte while the readout is still sending the captured record. The bench provokes this by sending a second 0x30 partway through the readout. It judges the result by requiring exactly DEPTH received bytes, matching the expected record, and no further bytes for a long window afterwards. A second case drives a full trigger pattern right after a byte that is not the arm command, and expects the output line to stay quiet.

// File: rtl/la_pkg.sv
package la_pkg;

    typedef enum logic [1:0] {
        LA_IDLE    = 2'd0,
        LA_ARMED   = 2'd1,
        LA_CAPTURE = 2'd2,
        LA_READOUT = 2'd3
    } la_state_e;

    localparam logic [7:0] CMD_ARM = 8'h30;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

endpackage

// File: rtl/la_uart_rx.sv
module la_uart_rx #(
    parameter int CLKS_PER_BIT = 868
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_pin,
    output logic       byte_valid,
    output logic [7:0] byte_data
);
    import la_pkg::*;

    localparam int CNT_W = $clog2(CLKS_PER_BIT + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(CLKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(CLKS_PER_BIT / 2 - 1);

    logic            sync1, sync2;
    rx_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic [2:0]      bit_idx;
    logic [7:0]      shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1      <= 1'b1;
            sync2      <= 1'b1;
            st         <= RX_IDLE;
            cnt        <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            sync1      <= rx_pin;
            sync2      <= sync1;
            byte_valid <= 1'b0;
            case (st)
                RX_IDLE: begin
                    cnt <= '0;
                    if (!sync2) st <= RX_START;
                end
                RX_START: begin
                    if (cnt == HALF) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        st      <= sync2 ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == FULL) begin
                        cnt   <= '0;
                        shreg <= {sync2, shreg[7:1]};
                        if (bit_idx == 3'd7) st <= RX_STOP;
                        else bit_idx <= bit_idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == FULL) begin
                        byte_valid <= sync2;
                        byte_data  <= shreg;
                        st         <= RX_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/la_uart_tx.sv
module la_uart_tx #(
    parameter int CLKS_PER_BIT = 868
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] data,
    output logic       busy,
    output logic       tx_pin
);
    localparam int CNT_W   = $clog2(CLKS_PER_BIT + 1);
    localparam int FRAME_W = 10;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(CLKS_PER_BIT - 1);

    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   cnt;
    logic [3:0]         nbit;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            frame <= '1;
            cnt   <= '0;
            nbit  <= '0;
        end else if (!busy) begin
            if (start) begin
                frame <= {1'b1, data, 1'b0};
                busy  <= 1'b1;
                cnt   <= '0;
                nbit  <= '0;
            end
        end else if (cnt == FULL) begin
            cnt   <= '0;
            frame <= {1'b1, frame[FRAME_W-1:1]};
            if (nbit == 4'(FRAME_W - 1)) busy <= 1'b0;
            else nbit <= nbit + 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tx_pin = busy ? frame[0] : 1'b1;
endmodule

// File: rtl/la_sample_mem.sv
module la_sample_mem #(
    parameter int SW    = 6,
    parameter int DEPTH = 4096
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [SW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [SW-1:0]            rdata
);
    logic [SW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/la_capture_core.sv
module la_capture_core #(
    parameter int         CLK_HZ      = 100_000_000,
    parameter int         BAUD        = 115_200,
    parameter int         DEPTH       = 4096,
    parameter int         D_W         = 3,
    parameter logic [D_W-1:0] TRIG_D_CODE = 3'b101
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           uart_rx,
    output logic           uart_tx,
    input  logic           probe_a,
    input  logic           probe_b,
    input  logic           probe_c,
    input  logic [D_W-1:0] probe_d
);
    import la_pkg::*;

    localparam int CLKS_PER_BIT = CLK_HZ / BAUD;
    localparam int SW           = 3 + D_W;
    localparam int AW           = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    la_state_e      state_q;
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic           last_sent;
    logic           rx_valid;
    logic [7:0]     rx_byte;
    logic           tx_busy, tx_start;
    logic [SW-1:0]  sample, rd_sample;
    logic           trig_a, trig_b, trig_any, mem_we;

    assign sample   = {probe_a, probe_b, probe_c, probe_d};
    assign trig_a   = probe_a & probe_b & ~probe_c;
    assign trig_b   = (probe_d == TRIG_D_CODE);
    assign trig_any = trig_a | trig_b;
    assign mem_we   = (state_q == LA_CAPTURE) || (state_q == LA_ARMED && trig_any);
    assign tx_start = (state_q == LA_READOUT) && !tx_busy && !last_sent;

    la_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk(clk), .rst(rst), .rx_pin(uart_rx),
        .byte_valid(rx_valid), .byte_data(rx_byte)
    );

    la_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk(clk), .rst(rst), .start(tx_start),
        .data(8'(rd_sample)), .busy(tx_busy), .tx_pin(uart_tx)
    );

    la_sample_mem #(.SW(SW), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(mem_we), .waddr(wr_ptr), .wdata(sample),
        .raddr(rd_ptr), .rdata(rd_sample)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= LA_IDLE;
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            last_sent <= 1'b0;
        end else begin
            case (state_q)
                LA_IDLE: begin
                    wr_ptr <= '0;
                    if (rx_valid && rx_byte == CMD_ARM) state_q <= LA_ARMED;
                end
                LA_ARMED: begin
                    if (trig_any) begin
                        wr_ptr  <= wr_ptr + 1'b1;
                        state_q <= LA_CAPTURE;
                    end
                end
                LA_CAPTURE: begin
                    if (wr_ptr == LAST_ADDR) begin
                        rd_ptr    <= '0;
                        last_sent <= 1'b0;
                        state_q   <= LA_READOUT;
                    end else begin
                        wr_ptr <= wr_ptr + 1'b1;
                    end
                end
                LA_READOUT: begin
                    if (tx_start) begin
                        if (rd_ptr == LAST_ADDR) last_sent <= 1'b1;
                        else rd_ptr <= rd_ptr + 1'b1;
                    end
                    if (last_sent && !tx_busy) state_q <= LA_IDLE;
                end
                default: state_q <= LA_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/la_capture_chk.sv
module la_capture_chk (
    input logic             clk,
    input logic             rst,
    input la_pkg::la_state_e state_q,
    input logic             rx_valid,
    input logic [7:0]       rx_byte,
    input logic             tx_busy,
    input logic             uart_tx
);
    import la_pkg::*;

    // R1
    reset_line_high_chk: assert property (@(posedge clk) rst |=> uart_tx);

    // R2
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == LA_IDLE && !(rx_valid && rx_byte == CMD_ARM)) |=> state_q == LA_IDLE);

    // R3
    armed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == LA_ARMED) |-> uart_tx);

    // R8
    capture_no_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == LA_CAPTURE) |=> (state_q == LA_CAPTURE || state_q == LA_READOUT));

    // R7
    readout_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == LA_READOUT && tx_busy) |=> state_q == LA_READOUT);

    // R6
    busy_only_readout_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && !$past(tx_busy)) |-> state_q == LA_READOUT);
endmodule

bind la_capture_core la_capture_chk u_chk (
    .clk(clk), .rst(rst), .state_q(state_q), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_busy(tx_busy), .uart_tx(uart_tx)
);

// File: tb/test_la_capture_core.sv
module test_la_capture_core;
    localparam int CLK_PERIOD = 10;
    localparam int CPB        = 8;
    localparam int DEPTH      = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       uart_rx = 1'b1;
    logic       uart_tx;
    logic [5:0] pv = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [7:0] got [64];
    int         got_n = 0;
    logic [5:0] expv [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    la_capture_core #(
        .CLK_HZ(CPB * 100), .BAUD(100), .DEPTH(DEPTH), .D_W(3), .TRIG_D_CODE(3'b101)
    ) i_la_capture_core (
        .clk(clk), .rst(rst), .uart_rx(uart_rx), .uart_tx(uart_tx),
        .probe_a(pv[5]), .probe_b(pv[4]), .probe_c(pv[3]), .probe_d(pv[2:0])
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // serial monitor on the output line, samples at mid-bit on falling clock
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && uart_tx == 1'b0) begin
                logic [7:0] b;
                repeat (CPB/2 - 1) @(negedge clk);
                check(uart_tx == 1'b0, "R6 start bit", uart_tx, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (CPB) @(negedge clk);
                    b[i] = uart_tx;
                end
                repeat (CPB) @(negedge clk);
                check(uart_tx == 1'b1, "R6 stop bit", uart_tx, 1);
                if (got_n < 64) got[got_n] = b;
                got_n++;
            end
        end
    end

    task automatic send_byte(input logic [7:0] v);
        logic [9:0] fr;
        fr = {1'b1, v, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            uart_rx = fr[i];
            repeat (CPB - 1) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        got_n = 0;
    endtask

    // drives a capture pattern starting with 'first' on consecutive clocks
    task automatic drive_pattern(input logic [5:0] first);
        for (int k = 0; k < DEPTH + 2; k++) begin
            @(negedge clk);
            pv = (k == 0) ? first : 6'((k * 7 + 3) & 6'h3f);
            if (k < DEPTH) expv[k] = pv;
        end
        @(negedge clk);
        pv = '0;
    endtask

    task automatic wait_bytes(input int n);
        for (int i = 0; i < 4000 && got_n < n; i++) @(negedge clk);
    endtask

    task automatic compare_record(input string req);
        check(got_n == DEPTH, {req, " byte count"}, got_n, DEPTH);
        for (int k = 0; k < DEPTH && k < got_n; k++)
            check(got[k] == {2'b00, expv[k]}, req, got[k], {2'b00, expv[k]});
    endtask

    task automatic t_reset_state();
        do_reset();
        check(uart_tx == 1'b1, "R1 line high after reset", uart_tx, 1);
        repeat (200) @(negedge clk);
        check(got_n == 0, "R1 no byte after reset", got_n, 0);
    endtask

    task automatic t_wrong_byte();
        do_reset();
        send_byte(8'h31);
        drive_pattern(6'b110010);
        repeat (300) @(negedge clk);
        check(got_n == 0, "R2 non-arm byte ignored", got_n, 0);
    endtask

    task automatic t_term_a_and_overlap();
        do_reset();
        send_byte(8'h30);
        pv = 6'b111100;
        repeat (200) @(negedge clk);
        check(got_n == 0, "R3 armed without trigger sends nothing", got_n, 0);
        fork
            drive_pattern(6'b110010);
            begin
                repeat (60) @(negedge clk);
                send_byte(8'h30);
            end
        join
        wait_bytes(DEPTH);
        compare_record("R5 R4 record term A");
        repeat (400) @(negedge clk);
        check(got_n == DEPTH, "R8 arm during readout ignored", got_n, DEPTH);
    endtask

    task automatic t_term_b_rearm();
        got_n = 0;
        send_byte(8'h30);
        pv = 6'b000100;
        repeat (50) @(negedge clk);
        check(got_n == 0, "R7 rearmed waits for trigger", got_n, 0);
        drive_pattern(6'b001101);
        wait_bytes(DEPTH);
        compare_record("R3 R6 record term B");
    endtask

    task automatic t_reset_mid_capture();
        do_reset();
        send_byte(8'h30);
        fork
            drive_pattern(6'b110000);
            begin
                repeat (6) @(negedge clk);
                rst = 1'b1;
                @(negedge clk);
                check(uart_tx == 1'b1, "R9 line high in reset", uart_tx, 1);
                repeat (2) @(negedge clk);
                rst = 1'b0;
            end
        join
        repeat (400) @(negedge clk);
        check(got_n == 0, "R9 abandoned capture sends nothing", got_n, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        t_reset_state();
        t_wrong_byte();
        t_term_a_and_overlap();
        t_term_b_rearm();
        t_reset_mid_capture();
        finish_run();
    end
endmodule